// File: doc/BRIEF.md
# Write-Through Single-Word Cache Controller

This block is a blocking, direct-mapped cache placed between a processor-side request port and a memory-side port. Each of its lines holds one data word, a stored tag and a valid flag. A read that finds its word in the cache is answered from the line store. A read that misses fetches the word from memory, fills the line and then answers. Every write is passed on to memory. The cached copy is refreshed only when the written address is already resident, and a write never allocates a line.

Both ports use valid/ready handshakes, and only one request is in flight at a time. An accepted request's address, direction and write data are captured in a register, so the upstream side may change its inputs freely once it has been accepted. A synchronous, active-high reset marks every line empty.

The controller moves through six states. IDLE is the only state that accepts work. From IDLE, accepting a read takes it to LOOKUP and accepting a write takes it to STORE. LOOKUP returns to IDLE on a hit (answering in that cycle) or goes to FETCH on a miss. FETCH holds the memory read request until memory takes it, then goes to AWAIT. AWAIT waits for returned data, writes it into the line and goes to REPLY. REPLY answers upstream and returns to IDLE. STORE holds the memory write request until memory takes it, updates the line on a hit, and returns to IDLE.

Top module: `wt_cache_ctrl`

## Requirements
- R1: The byte address is split as tag = bits [31:10], line index = bits [9:2]; bits [1:0] are ignored, so two addresses that differ only there select the same word and hit the same line.
- R2: There are 256 lines of one 32-bit word each; lines with different indices hold their words independently.
- R3: A read hit raises up_rvalid with the cached word in the cycle after acceptance, for exactly one cycle, and issues no memory request.
- R4: A read miss issues one memory read (dn_write = 0) at the accepted address, waits for dn_rvalid, stores the returned word and tag in the line, marks it valid and then pulses up_rvalid with that word; a later read of the same word hits.
- R5: Every write issues one memory write (dn_write = 1) carrying the accepted address and data, and never raises up_rvalid.
- R6: A write whose tag matches a valid line updates the cached word; a write miss leaves the line's tag, data and valid flag unchanged.
- R7: A request is accepted only in a cycle where up_valid and up_ready are both high; up_ready is high only in IDLE and stays low from acceptance until the read answer has been given or the memory write has been taken.
- R8: Once dn_valid is raised it stays high, with dn_addr, dn_wdata and dn_write unchanged, until a cycle in which dn_ready is high.
- R9: Changes on up_addr, up_wdata and up_write after acceptance do not affect the request in progress.
- R10: While rst is high at a clock edge, every line becomes invalid and the controller returns to IDLE (up_ready high, dn_valid and up_rvalid low).
- R11: A hit requires both the line's valid flag and a stored tag equal to address bits [31:10]; a different tag at the same index is a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request present |
| up_write | input | 1 | Request direction: 1 write, 0 read |
| up_addr | input | 32 | Request byte address |
| up_wdata | input | 32 | Write data |
| up_ready | output | 1 | Controller can take a request |
| up_rvalid | output | 1 | Read answer present (one-cycle pulse) |
| up_rdata | output | 32 | Read answer word |
| dn_valid | output | 1 | Memory request present |
| dn_write | output | 1 | Memory request direction: 1 write, 0 read |
| dn_addr | output | 32 | Memory request byte address |
| dn_wdata | output | 32 | Memory write data |
| dn_ready | input | 1 | Memory takes the request |
| dn_rvalid | input | 1 | Memory read data present |
| dn_rdata | input | 32 | Memory read data |

## Verification
The hardest situation to reach from the ports is a write miss that lands on an index already holding a valid line with a different tag, followed by a read of the resident word: only that order shows whether the write wrongly allocated or corrupted the line. Directed sequences build it explicitly, and the random phase draws addresses from three tags and six indices so such collisions, evictions and write hits recur many times. Memory back-pressure is randomised in that phase so that requests are held across stalled cycles, and the upstream inputs are scrambled right after each acceptance to expose any use of unregistered request fields.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_FETCH  = 3'd2,
        ST_AWAIT  = 3'd3,
        ST_REPLY  = 3'd4,
        ST_STORE  = 3'd5
    } wtc_state_e;

endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic              vflag   [LINES];
    logic [TAG_W-1:0]  tag_arr [LINES];
    logic [DATA_W-1:0] dat_arr [LINES];

    // One valid flop per line; reset clears them all.
    for (genvar g = 0; g < LINES; g++) begin : g_vflag
        always_ff @(posedge clk) begin
            if (rst) begin
                vflag[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                vflag[g] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_arr[wr_idx] <= wr_tag;
            dat_arr[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = vflag[rd_idx];
    assign rd_tag   = tag_arr[rd_idx];
    assign rd_data  = dat_arr[rd_idx];

endmodule

// File: rtl/wtc_tag_match.sv
module wtc_tag_match #(
    parameter int TAG_W = 22
) (
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit
);
    assign hit = line_valid && (line_tag == req_tag);
endmodule

// File: rtl/wtc_ctrl_fsm.sv
module wtc_ctrl_fsm
    import wtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic up_valid,
    input  logic up_write,
    input  logic hit,
    input  logic dn_ready,
    input  logic dn_rvalid,
    output logic accept,
    output logic up_ready,
    output logic up_rvalid,
    output logic dn_valid,
    output logic dn_write,
    output logic fill_en,
    output logic upd_en
);
    wtc_state_e st, nxt;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // Transitions.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:   if (up_valid) nxt = up_write ? ST_STORE : ST_LOOKUP;
            ST_LOOKUP: nxt = hit ? ST_IDLE : ST_FETCH;
            ST_FETCH:  if (dn_ready) nxt = ST_AWAIT;
            ST_AWAIT:  if (dn_rvalid) nxt = ST_REPLY;
            ST_REPLY:  nxt = ST_IDLE;
            ST_STORE:  if (dn_ready) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Outputs per state.
    always_comb begin
        up_ready  = 1'b0;
        up_rvalid = 1'b0;
        dn_valid  = 1'b0;
        dn_write  = 1'b0;
        fill_en   = 1'b0;
        upd_en    = 1'b0;
        accept    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                up_ready = 1'b1;
                accept   = up_valid;
            end
            ST_LOOKUP: up_rvalid = hit;
            ST_FETCH:  dn_valid  = 1'b1;
            ST_AWAIT:  fill_en   = dn_rvalid;
            ST_REPLY:  up_rvalid = 1'b1;
            ST_STORE: begin
                dn_valid = 1'b1;
                dn_write = 1'b1;
                upd_en   = dn_ready && hit;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    input  logic              up_write,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_wdata,
    output logic              up_ready,
    output logic              up_rvalid,
    output logic [DATA_W-1:0] up_rdata,
    output logic              dn_valid,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_ready,
    input  logic              dn_rvalid,
    input  logic [DATA_W-1:0] dn_rdata
);
    localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;
    localparam int IDX_LO = OFS_W;
    localparam int TAG_LO = OFS_W + IDX_W;

    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              accept;
    logic              fill_en;
    logic              upd_en;
    logic              hit;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] line_data;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;

    // Capture the accepted request.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_addr  <= '0;
            req_wdata <= '0;
        end else if (accept) begin
            req_addr  <= up_addr;
            req_wdata <= up_wdata;
        end
    end

    assign req_idx = req_addr[TAG_LO-1:IDX_LO];
    assign req_tag = req_addr[ADDR_W-1:TAG_LO];

    wtc_line_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (req_idx),
        .rd_valid(line_valid),
        .rd_tag  (line_tag),
        .rd_data (line_data),
        .wr_en   (fill_en || upd_en),
        .wr_idx  (req_idx),
        .wr_tag  (req_tag),
        .wr_data (fill_en ? dn_rdata : req_wdata)
    );

    wtc_tag_match #(
        .TAG_W(TAG_W)
    ) u_match (
        .line_valid(line_valid),
        .line_tag  (line_tag),
        .req_tag   (req_tag),
        .hit       (hit)
    );

    wtc_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .up_valid (up_valid),
        .up_write (up_write),
        .hit      (hit),
        .dn_ready (dn_ready),
        .dn_rvalid(dn_rvalid),
        .accept   (accept),
        .up_ready (up_ready),
        .up_rvalid(up_rvalid),
        .dn_valid (dn_valid),
        .dn_write (dn_write),
        .fill_en  (fill_en),
        .upd_en   (upd_en)
    );

    assign up_rdata = line_data;
    assign dn_addr  = req_addr;
    assign dn_wdata = req_wdata;

endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              up_valid,
    input logic              up_write,
    input logic [ADDR_W-1:0] up_addr,
    input logic [DATA_W-1:0] up_wdata,
    input logic              up_ready,
    input logic              up_rvalid,
    input logic              dn_valid,
    input logic              dn_write,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [DATA_W-1:0] dn_wdata,
    input logic              dn_ready
);
    logic rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            assert_reset_idle_R10: assert (up_ready && !dn_valid && !up_rvalid)
                else $error("controller not idle after reset");
        end
    end

    assert_resp_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        up_rvalid |=> !up_rvalid);

    assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (up_rvalid || dn_valid) |-> !up_ready);

    assert_accept_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_ready) |=> !up_ready);

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr)
                                     && $stable(dn_wdata) && $stable(dn_write)));

    assert_write_issue_R5: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_ready && up_write) |=> (dn_valid && dn_write
            && dn_addr == $past(up_addr) && dn_wdata == $past(up_wdata)));

    assert_write_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_write) |-> !up_rvalid);

    assert_read_no_early_mem_R3: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_ready && !up_write) |=> !dn_valid);

endmodule

bind wt_cache_ctrl wtc_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .up_valid (up_valid),
    .up_write (up_write),
    .up_addr  (up_addr),
    .up_wdata (up_wdata),
    .up_ready (up_ready),
    .up_rvalid(up_rvalid),
    .dn_valid (dn_valid),
    .dn_write (dn_write),
    .dn_addr  (dn_addr),
    .dn_wdata (dn_wdata),
    .dn_ready (dn_ready)
);

// File: tb/wt_cache_ctrl_tb.sv
module wt_cache_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_valid = 1'b0;
    logic        up_write = 1'b0;
    logic [31:0] up_addr = '0;
    logic [31:0] up_wdata = '0;
    logic        up_ready;
    logic        up_rvalid;
    logic [31:0] up_rdata;
    logic        dn_valid;
    logic        dn_write;
    logic [31:0] dn_addr;
    logic [31:0] dn_wdata;
    logic        dn_ready = 1'b0;
    logic        dn_rvalid = 1'b0;
    logic [31:0] dn_rdata = '0;

    always #5 clk = ~clk;

    wt_cache_ctrl u_dut (
        .clk(clk), .rst(rst),
        .up_valid(up_valid), .up_write(up_write), .up_addr(up_addr), .up_wdata(up_wdata),
        .up_ready(up_ready), .up_rvalid(up_rvalid), .up_rdata(up_rdata),
        .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_ready(dn_ready), .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model: written words, otherwise a hash of the word address.
    logic [31:0] mstore [int unsigned];
    function automatic logic [31:0] mword(input logic [31:0] a);
        int unsigned k = {2'b00, a[31:2]};
        if (mstore.exists(k)) return mstore[k];
        return ({2'b00, a[31:2]} * 32'h9E37_79B1) ^ 32'h1357_2468;
    endfunction

    int          rd_cnt = 0, wr_cnt = 0;
    logic [31:0] last_rd_a = '0, last_wr_a = '0, last_wr_d = '0;
    bit          stall = 1'b0;
    bit          pend = 1'b0;
    int          cdown = 0;
    logic [31:0] pdata = '0;
    bit          hold = 1'b0;
    logic [31:0] hold_a = '0, hold_d = '0;
    bit          hold_w = 1'b0;

    // Memory side, driven and sampled at falling edges.
    initial begin
        forever begin
            @(negedge clk);
            if (hold) begin
                chk(dn_valid && dn_addr == hold_a && dn_wdata == hold_d && dn_write == hold_w,
                    "R8", "request held while stalled", dn_addr, hold_a);
            end
            dn_rvalid = 1'b0;
            dn_rdata  = $urandom;
            if (pend) begin
                if (cdown == 0) begin
                    dn_rvalid = 1'b1;
                    dn_rdata  = pdata;
                    pend      = 1'b0;
                end else begin
                    cdown--;
                end
            end
            dn_ready = stall ? ($urandom % 3 == 0) : 1'b1;
            hold   = dn_valid && !dn_ready;
            hold_a = dn_addr;
            hold_d = dn_wdata;
            hold_w = dn_write;
            if (dn_valid && dn_ready) begin
                if (dn_write) begin
                    wr_cnt++;
                    last_wr_a = dn_addr;
                    last_wr_d = dn_wdata;
                    mstore[{2'b00, dn_addr[31:2]}] = dn_wdata;
                end else begin
                    rd_cnt++;
                    last_rd_a = dn_addr;
                    pend  = 1'b1;
                    cdown = $urandom % 4;
                    pdata = mword(dn_addr);
                end
            end
        end
    end

    // Expected line state.
    bit          ev [256];
    logic [21:0] et [256];

    task automatic cpu_op(input bit w, input logic [31:0] a, input logic [31:0] d,
                          input string req);
        int rd0, wr0, n;
        bit exp_hit, saw_resp;
        logic [7:0]  ix = a[9:2];
        logic [21:0] tg = a[31:10];
        logic [31:0] exp_d;
        @(negedge clk);
        up_valid = 1'b1; up_write = w; up_addr = a; up_wdata = d;
        n = 0;
        while (!up_ready && n < 100) begin @(negedge clk); n++; end
        rd0 = rd_cnt; wr0 = wr_cnt;
        @(negedge clk);
        up_valid = 1'b0; up_write = 1'($urandom); up_addr = $urandom; up_wdata = $urandom;
        chk(!up_ready, "R7", "ready low after acceptance", 32'(up_ready), 32'd0);
        if (!w) begin
            exp_hit = ev[ix] && (et[ix] == tg);
            n = 0;
            while (!up_rvalid && n < 200) begin @(negedge clk); n++; end
            exp_d = mword(a);
            chk(up_rvalid, "R4", "read answered", 32'(up_rvalid), 32'd1);
            chk(up_rdata == exp_d, req, "read data", up_rdata, exp_d);
            if (exp_hit) begin
                chk(n == 0 && rd_cnt == rd0, "R3", "hit one-cycle latency, no memory read",
                    32'(n), 32'd0);
            end else begin
                chk(rd_cnt == rd0 + 1, (req == "R11") ? "R11" : "R4", "miss fetches once",
                    32'(rd_cnt - rd0), 32'd1);
                chk(last_rd_a == a, "R9", "fetch address unaffected by input changes",
                    last_rd_a, a);
            end
            ev[ix] = 1'b1;
            et[ix] = tg;
            @(negedge clk);
            chk(!up_rvalid, "R3", "answer is a single pulse", 32'(up_rvalid), 32'd0);
            chk(up_ready, "R7", "ready after read", 32'(up_ready), 32'd1);
        end else begin
            n = 0; saw_resp = 1'b0;
            while (wr_cnt == wr0 && n < 200) begin
                saw_resp |= up_rvalid;
                @(negedge clk); n++;
            end
            chk(wr_cnt == wr0 + 1, "R5", "one memory write", 32'(wr_cnt - wr0), 32'd1);
            chk(last_wr_a == a, "R9", "write address registered", last_wr_a, a);
            chk(last_wr_d == d, "R9", "write data registered", last_wr_d, d);
            @(negedge clk);
            saw_resp |= up_rvalid;
            chk(!saw_resp, "R5", "write gives no read answer", 32'(saw_resp), 32'd0);
            chk(up_ready, "R7", "ready after write taken", 32'(up_ready), 32'd1);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk(up_ready && !dn_valid && !up_rvalid, "R10", "idle under reset",
                {29'd0, up_ready, dn_valid, up_rvalid}, 32'd4);
        end
        rst = 1'b0;
        for (int i = 0; i < 256; i++) ev[i] = 1'b0;
    endtask

    localparam logic [31:0] A_ADDR = 32'h0000_1A34;
    localparam logic [31:0] B_ADDR = 32'h0000_5E34; // same index as A, other tag
    localparam logic [31:0] C_ADDR = 32'h0000_9234; // same index as A, third tag

    initial begin
        void'($urandom(32'h00C0_FFEE));
        for (int i = 0; i < 256; i++) begin ev[i] = 1'b0; et[i] = '0; end
        do_reset();

        // Miss, then hit, then offset alias.
        cpu_op(1'b0, A_ADDR, 32'd0, "R4");
        cpu_op(1'b0, A_ADDR, 32'd0, "R3");
        cpu_op(1'b0, A_ADDR | 32'd3, 32'd0, "R1");
        // Tag mismatch at the same index evicts A.
        cpu_op(1'b0, B_ADDR, 32'd0, "R11");
        cpu_op(1'b0, A_ADDR, 32'd0, "R11");
        // Write hit refreshes the cached word.
        cpu_op(1'b1, A_ADDR, 32'hCAFE_0001, "R6");
        cpu_op(1'b0, A_ADDR, 32'd0, "R6");
        // Write miss does not allocate or disturb the resident line.
        cpu_op(1'b1, C_ADDR, 32'hBEEF_0002, "R6");
        cpu_op(1'b0, A_ADDR, 32'd0, "R6");
        cpu_op(1'b0, C_ADDR, 32'd0, "R6");
        // Lowest and highest index hold separate words.
        cpu_op(1'b0, 32'h0000_0000, 32'd0, "R2");
        cpu_op(1'b0, 32'h0000_03FC, 32'd0, "R2");
        cpu_op(1'b0, 32'h0000_0000, 32'd0, "R2");
        cpu_op(1'b0, 32'h0000_03FC, 32'd0, "R2");
        // Reset forgets every line.
        do_reset();
        cpu_op(1'b0, 32'h0000_03FC, 32'd0, "R10");

        // Random phase with memory stalls.
        stall = 1'b1;
        for (int k = 0; k < 400; k++) begin
            logic [31:0] ra;
            ra = {20'd0, 2'($urandom % 3), 8'($urandom % 6), 2'($urandom)};
            if ($urandom % 2 == 0) cpu_op(1'b1, ra, $urandom, "R5");
            else                   cpu_op(1'b0, ra, 32'd0, "R6");
        end
        stall = 1'b0;

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule